// File: doc/BRIEF.md
# Page-Bounded Stream Prefetcher

This block sits on the miss path of a second-level cache and turns short runs of nearby misses into prefetch requests. It keeps eight trackers, each bound to one distinct 4 KB page. A tracker arms only when two successive misses land in its page, in different 64-byte blocks, and less than 256 bytes apart. The order of those two misses sets the stream direction, up or down.

An armed stream offers the blocks that follow its latest demand block, one after another in its direction. It runs at most two blocks ahead of that demand block and never offers a block outside its own page. Demand hits that the cache reports move the stream's anchor forward and free lookahead slots. All streams share one prefetch output with a valid/ready handshake, and a round-robin arbiter chooses between them. A request that is never accepted has no effect on correctness.

Address layout used throughout: the page number is address bits [31:12], the block index within the page is bits [11:6], and bits [5:0] are the byte within the block.

Top module: `stream_prefetcher`

## Requirements
- R1: While reset is asserted, and after it is released, pfValid is 0 and every tracker is empty. After reset, a single miss to a page that was tracked before the reset produces no prefetch.
- R2: A tracker arms only when it sees two successive misses (addr[31:12] equal) whose blocks (addr[11:6]) differ and whose byte addresses are less than 256 apart. A single miss, a pair exactly 256 or more bytes apart, or a pair in the same block leaves pfValid at 0.
- R3: When the second triggering miss has the higher address, the stream ascends. It offers the block-aligned addresses (low 6 bits zero) of the second miss's block plus 1, then plus 2.
- R4: When the second triggering miss has the lower address, the stream descends. It offers the blocks one and then two below the second miss's block.
- R5: A stream has at most 2 accepted prefetches outstanding beyond its latest demand block. A demand hit k blocks ahead in the stream direction makes that block the new anchor and frees k slots. A hit at or behind the anchor changes nothing.
- R6: No offered address ever leaves the stream's 4 KB page. When the next block would cross the page edge, the stream stops offering.
- R7: Up to eight trackers exist, each on a different page. A miss to a tracked page reuses its tracker. A miss to an untracked page takes a free tracker, or else replaces the tracker least recently touched by a miss or a demand hit.
- R8: When several streams can issue, grants rotate round-robin. After a grant to tracker i, the next grant goes to the first ready tracker after i, wrapping around.
- R9: While pfValid is 1 and pfReady is 0, with no miss or hit arriving, pfValid stays 1 and pfAddr stays unchanged. No stream advances.
- R10: A miss to a tracked page that fails the distance test deactivates that stream and re-anchors it at the new miss. A following qualifying miss re-arms it with a freshly chosen direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| missValid | input | 1 | A cache miss is presented this cycle |
| missAddr | input | 32 | Byte address of the miss |
| hitValid | input | 1 | A demand hit is reported this cycle (ignored when missValid is 1) |
| hitAddr | input | 32 | Byte address of the demand hit |
| pfReady | input | 1 | Downstream accepts the offered prefetch |
| pfValid | output | 1 | A prefetch request is offered |
| pfAddr | output | 32 | Block-aligned address of the offered prefetch |

## Verification
Some properties are checked on every cycle. No tracker exceeds its lookahead limit, no two trackers share a page, and each grant goes to a tracker that is ready to issue. Every offer stays on the page of an active stream, an unaccepted offer is held steady, and no offer appears before two misses have arrived. Other behaviour shows only in the bench's scenarios, through the exact sequence of offered addresses. That covers ascending and descending address order, the 256-byte threshold, re-anchoring on demand hits, the round-robin grant order, and which page least-recently-used replacement evicts.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam int ADDR_W      = 32;
  localparam int NUM_STREAMS = 8;
  localparam int PAGE_BITS   = 12;
  localparam int BLK_BITS    = 6;
  localparam int DIST_LIMIT  = 256;
  localparam int AHEAD_MAX   = 2;

  localparam int IDX_W   = $clog2(NUM_STREAMS);
  localparam int PAGE_W  = ADDR_W - PAGE_BITS;
  localparam int BIDX_W  = PAGE_BITS - BLK_BITS;
  localparam int AHEAD_W = $clog2(AHEAD_MAX + 1);

  typedef logic [PAGE_W-1:0]    page_t;
  typedef logic [PAGE_BITS-1:0] off_t;
  typedef logic [BIDX_W-1:0]    bidx_t;
  typedef logic [AHEAD_W-1:0]   ahead_t;
  typedef logic [IDX_W-1:0]     idx_t;

  // Strobes from control to the tracker datapath
  typedef struct packed {
    logic   missUpd;
    logic   missArm;
    logic   missDir;   // 1 = descending
    idx_t   missIdx;
    page_t  missPage;
    off_t   missOff;
    logic   hitUpd;
    idx_t   hitIdx;
    off_t   hitOff;
    ahead_t hitAhead;
    logic   issue;
    idx_t   issueIdx;
  } strobe_t;
endpackage

// File: rtl/spf_lru.sv
module spf_lru
  import spf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   touch,
  input  idx_t                   touchIdx,
  input  logic [NUM_STREAMS-1:0] inUse,
  output idx_t                   victim
);
  idx_t age [NUM_STREAMS];
  idx_t freeIdx;
  idx_t oldestIdx;
  logic anyFree;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_STREAMS; i++) age[i] <= idx_t'(i);
    end else if (touch) begin
      for (int i = 0; i < NUM_STREAMS; i++) begin
        if (idx_t'(i) == touchIdx) age[i] <= '0;
        else if (age[i] < age[touchIdx]) age[i] <= age[i] + idx_t'(1);
      end
    end
  end

  always_comb begin
    anyFree   = 1'b0;
    freeIdx   = '0;
    oldestIdx = '0;
    for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
      if (!inUse[i]) begin
        anyFree = 1'b1;
        freeIdx = idx_t'(i);
      end
      if (age[i] == idx_t'(NUM_STREAMS - 1)) oldestIdx = idx_t'(i);
    end
    victim = anyFree ? freeIdx : oldestIdx;
  end
endmodule

// File: rtl/spf_rr_arb.sv
module spf_rr_arb
  import spf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_STREAMS-1:0] req,
  input  logic                   advance,
  output logic                   any,
  output idx_t                   grant
);
  idx_t rrPtr;

  always_comb begin
    any   = |req;
    grant = '0;
    for (int k = NUM_STREAMS - 1; k >= 0; k--) begin
      int slot;
      slot = (int'(rrPtr) + k) % NUM_STREAMS;
      if (req[slot]) grant = idx_t'(slot);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rrPtr <= '0;
    else if (advance && any)
      rrPtr <= (grant == idx_t'(NUM_STREAMS - 1)) ? '0 : grant + idx_t'(1);
  end
endmodule

// File: rtl/spf_ctrl.sv
module spf_ctrl
  import spf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   missValid,
  input  logic [ADDR_W-1:0]      missAddr,
  input  logic                   hitValid,
  input  logic [ADDR_W-1:0]      hitAddr,
  input  logic                   pfReady,
  input  logic [NUM_STREAMS-1:0] trkValid,
  input  logic [NUM_STREAMS-1:0] trkActive,
  input  logic [NUM_STREAMS-1:0] trkDir,
  input  logic [NUM_STREAMS-1:0] eligible,
  input  page_t                  trkPage  [NUM_STREAMS],
  input  off_t                   trkOff   [NUM_STREAMS],
  input  ahead_t                 trkAhead [NUM_STREAMS],
  output strobe_t                strb,
  output logic                   pfValid,
  output idx_t                   grantIdx
);
  page_t missPage, hitPage;
  off_t  missOff, hitOff, lastOff;
  logic [NUM_STREAMS-1:0] missMatch, hitMatch;
  idx_t  missHitIdx, hitIdx, victim, missIdx, touchIdx;
  logic  missKnown, hitKnown, sameBlk, arm, issueNow, issueSame, fwdPos, hitUpd, touch;
  logic [PAGE_BITS:0] byteDiff, byteMag;
  bidx_t hitBlk, anchorBlk;
  logic [BIDX_W:0] fwd, aheadEff;
  ahead_t newAhead;

  assign missPage = missAddr[ADDR_W-1:PAGE_BITS];
  assign missOff  = missAddr[PAGE_BITS-1:0];
  assign hitPage  = hitAddr[ADDR_W-1:PAGE_BITS];
  assign hitOff   = hitAddr[PAGE_BITS-1:0];

  // Page lookup for both notification paths
  always_comb begin
    missHitIdx = '0;
    hitIdx     = '0;
    for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
      missMatch[i] = trkValid[i] && (trkPage[i] == missPage);
      hitMatch[i]  = trkValid[i] && trkActive[i] && (trkPage[i] == hitPage);
      if (missMatch[i]) missHitIdx = idx_t'(i);
      if (hitMatch[i])  hitIdx     = idx_t'(i);
    end
  end
  assign missKnown = |missMatch;
  assign hitKnown  = |hitMatch;

  // Distance test between successive misses to one page
  assign lastOff  = trkOff[missHitIdx];
  assign byteDiff = {1'b0, missOff} - {1'b0, lastOff};
  assign byteMag  = byteDiff[PAGE_BITS] ? (~byteDiff + 1'b1) : byteDiff;
  assign sameBlk  = missOff[PAGE_BITS-1:BLK_BITS] == lastOff[PAGE_BITS-1:BLK_BITS];
  assign arm      = missKnown && !sameBlk && (byteMag < (PAGE_BITS+1)'(DIST_LIMIT));
  assign missIdx  = missKnown ? missHitIdx : victim;

  // Demand-hit progress measured in stream direction
  assign hitBlk    = hitOff[PAGE_BITS-1:BLK_BITS];
  assign anchorBlk = trkOff[hitIdx][PAGE_BITS-1:BLK_BITS];
  assign fwd       = trkDir[hitIdx] ? ({1'b0, anchorBlk} - {1'b0, hitBlk})
                                    : ({1'b0, hitBlk} - {1'b0, anchorBlk});
  assign fwdPos    = !fwd[BIDX_W] && (fwd != '0);
  assign issueNow  = pfValid && pfReady;
  assign issueSame = issueNow && (grantIdx == hitIdx);
  assign aheadEff  = (BIDX_W+1)'(trkAhead[hitIdx]) + (BIDX_W+1)'(issueSame);
  assign newAhead  = (fwd >= aheadEff) ? '0 : AHEAD_W'(aheadEff - fwd);
  assign hitUpd    = hitValid && !missValid && hitKnown && fwdPos;

  assign touch    = missValid || hitUpd;
  assign touchIdx = missValid ? missIdx : hitIdx;

  spf_lru u_lru (
    .clk(clk), .rstN(rstN), .touch(touch), .touchIdx(touchIdx),
    .inUse(trkValid), .victim(victim)
  );

  spf_rr_arb u_arb (
    .clk(clk), .rstN(rstN), .req(eligible), .advance(pfReady),
    .any(pfValid), .grant(grantIdx)
  );

  always_comb begin
    strb          = '0;
    strb.missUpd  = missValid && !(missKnown && sameBlk);
    strb.missArm  = arm;
    strb.missDir  = byteDiff[PAGE_BITS];
    strb.missIdx  = missIdx;
    strb.missPage = missPage;
    strb.missOff  = missOff;
    strb.hitUpd   = hitUpd;
    strb.hitIdx   = hitIdx;
    strb.hitOff   = hitOff;
    strb.hitAhead = newAhead;
    strb.issue    = issueNow;
    strb.issueIdx = grantIdx;
  end
endmodule

// File: rtl/spf_datapath.sv
module spf_datapath
  import spf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  idx_t                   grantIdx,
  output logic [NUM_STREAMS-1:0] trkValid,
  output logic [NUM_STREAMS-1:0] trkActive,
  output logic [NUM_STREAMS-1:0] trkDir,
  output logic [NUM_STREAMS-1:0] eligible,
  output page_t                  trkPage  [NUM_STREAMS],
  output off_t                   trkOff   [NUM_STREAMS],
  output ahead_t                 trkAhead [NUM_STREAMS],
  output logic [ADDR_W-1:0]      pfAddr
);
  logic [BIDX_W:0]   nxtBlk   [NUM_STREAMS];
  logic [ADDR_W-1:0] candAddr [NUM_STREAMS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trkValid  <= '0;
      trkActive <= '0;
      trkDir    <= '0;
      for (int i = 0; i < NUM_STREAMS; i++) begin
        trkPage[i]  <= '0;
        trkOff[i]   <= '0;
        trkAhead[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_STREAMS; i++) begin
        if (strb.missUpd && strb.missIdx == idx_t'(i)) begin
          trkValid[i]  <= 1'b1;
          trkPage[i]   <= strb.missPage;
          trkOff[i]    <= strb.missOff;
          trkActive[i] <= strb.missArm;
          trkDir[i]    <= strb.missDir;
          trkAhead[i]  <= '0;
        end else if (strb.hitUpd && strb.hitIdx == idx_t'(i)) begin
          trkOff[i]   <= strb.hitOff;
          trkAhead[i] <= strb.hitAhead;
        end else if (strb.issue && strb.issueIdx == idx_t'(i)) begin
          trkAhead[i] <= trkAhead[i] + ahead_t'(1);
        end
      end
    end
  end

  // Per-tracker next block and readiness, all in parallel
  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_trk
    logic [BIDX_W:0] anchorExt, stepExt;
    assign anchorExt   = {1'b0, trkOff[g][PAGE_BITS-1:BLK_BITS]};
    assign stepExt     = (BIDX_W+1)'(trkAhead[g]) + (BIDX_W+1)'(1);
    assign nxtBlk[g]   = trkDir[g] ? (anchorExt - stepExt) : (anchorExt + stepExt);
    assign eligible[g] = trkValid[g] && trkActive[g] &&
                         (trkAhead[g] < ahead_t'(AHEAD_MAX)) && !nxtBlk[g][BIDX_W];
    assign candAddr[g] = {trkPage[g], nxtBlk[g][BIDX_W-1:0], {BLK_BITS{1'b0}}};
  end

  assign pfAddr = candAddr[grantIdx];
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
  import spf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              hitValid,
  input  logic [ADDR_W-1:0] hitAddr,
  input  logic              pfReady,
  output logic              pfValid,
  output logic [ADDR_W-1:0] pfAddr
);
  strobe_t strb;
  idx_t    grantIdx;
  logic [NUM_STREAMS-1:0] trkValid, trkActive, trkDir, eligible;
  page_t  trkPage  [NUM_STREAMS];
  off_t   trkOff   [NUM_STREAMS];
  ahead_t trkAhead [NUM_STREAMS];

  spf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missAddr(missAddr),
    .hitValid(hitValid), .hitAddr(hitAddr), .pfReady(pfReady),
    .trkValid(trkValid), .trkActive(trkActive), .trkDir(trkDir), .eligible(eligible),
    .trkPage(trkPage), .trkOff(trkOff), .trkAhead(trkAhead),
    .strb(strb), .pfValid(pfValid), .grantIdx(grantIdx)
  );

  spf_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .grantIdx(grantIdx),
    .trkValid(trkValid), .trkActive(trkActive), .trkDir(trkDir), .eligible(eligible),
    .trkPage(trkPage), .trkOff(trkOff), .trkAhead(trkAhead), .pfAddr(pfAddr)
  );
endmodule

// File: rtl/spf_checker.sv
module spf_checker
  import spf_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   missValid,
  input logic                   hitValid,
  input logic                   pfValid,
  input logic                   pfReady,
  input logic [ADDR_W-1:0]      pfAddr,
  input logic [NUM_STREAMS-1:0] trkValid,
  input logic [NUM_STREAMS-1:0] trkActive,
  input logic [NUM_STREAMS-1:0] eligible,
  input page_t                  trkPage  [NUM_STREAMS],
  input ahead_t                 trkAhead [NUM_STREAMS],
  input logic                   issue,
  input idx_t                   issueIdx
);
  logic [1:0] missSeen;
  logic aheadOk, pagesUnique, pageOwned;

  always_ff @(posedge clk) begin
    if (!rstN) missSeen <= '0;
    else if (missValid && missSeen != 2'd2) missSeen <= missSeen + 2'd1;
  end

  always_comb begin
    aheadOk     = 1'b1;
    pagesUnique = 1'b1;
    pageOwned   = 1'b0;
    for (int i = 0; i < NUM_STREAMS; i++) begin
      if (trkAhead[i] > ahead_t'(AHEAD_MAX)) aheadOk = 1'b0;
      if (trkValid[i] && trkActive[i] && trkPage[i] == pfAddr[ADDR_W-1:PAGE_BITS])
        pageOwned = 1'b1;
      for (int j = i + 1; j < NUM_STREAMS; j++)
        if (trkValid[i] && trkValid[j] && trkPage[i] == trkPage[j]) pagesUnique = 1'b0;
    end
  end

  p_no_early_pf_r2: assert property (@(posedge clk) disable iff (!rstN)
    pfValid |-> missSeen == 2'd2);
  p_offer_on_page_r6: assert property (@(posedge clk) disable iff (!rstN)
    pfValid |-> pageOwned);
  p_ahead_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    aheadOk);
  p_unique_page_r7: assert property (@(posedge clk) disable iff (!rstN)
    pagesUnique);
  p_grant_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    issue |-> eligible[issueIdx]);
  p_hold_offer_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && !pfReady && !missValid && !hitValid) |=> (pfValid && $stable(pfAddr)));
endmodule

bind stream_prefetcher spf_checker u_chk (
  .clk(clk), .rstN(rstN), .missValid(missValid), .hitValid(hitValid),
  .pfValid(pfValid), .pfReady(pfReady), .pfAddr(pfAddr),
  .trkValid(trkValid), .trkActive(trkActive), .eligible(eligible),
  .trkPage(trkPage), .trkAhead(trkAhead),
  .issue(strb.issue), .issueIdx(strb.issueIdx)
);

// File: tb/tb_stream_prefetcher.sv
module tb_stream_prefetcher;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_MISS = 2'd0;
  localparam logic [1:0] OP_HIT  = 2'd1;
  localparam logic [1:0] OP_PULL = 2'd2;
  localparam logic [1:0] OP_IDLE = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic        expV;
    logic [31:0] expA;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 26;
  localparam vec_t TBL [NVEC] = '{
    '{OP_MISS, 32'h0001_0040, 1'b0, 32'h0, 4'd2},        // R2 single miss
    '{OP_MISS, 32'h0001_0100, 1'b1, 32'h0001_0140, 4'd3}, // R3 arm ascending
    '{OP_PULL, 32'h0,         1'b1, 32'h0001_0180, 4'd3}, // R3
    '{OP_PULL, 32'h0,         1'b0, 32'h0,         4'd5}, // R5 cap reached
    '{OP_HIT,  32'h0001_0140, 1'b1, 32'h0001_01C0, 4'd5}, // R5 one slot freed
    '{OP_PULL, 32'h0,         1'b0, 32'h0,         4'd5}, // R5
    '{OP_HIT,  32'h0001_0200, 1'b1, 32'h0001_0240, 4'd5}, // R5 jump resets lookahead
    '{OP_HIT,  32'h0001_0100, 1'b1, 32'h0001_0240, 4'd5}, // R5 hit behind ignored
    '{OP_MISS, 32'h0001_0800, 1'b0, 32'h0,         4'd10},// R10 far miss
    '{OP_MISS, 32'h0001_07C0, 1'b1, 32'h0001_0780, 4'd4}, // R4 re-armed descending
    '{OP_PULL, 32'h0,         1'b1, 32'h0001_0740, 4'd4}, // R4
    '{OP_PULL, 32'h0,         1'b0, 32'h0,         4'd5}, // R5
    '{OP_MISS, 32'h0002_0F40, 1'b0, 32'h0,         4'd2}, // R2
    '{OP_MISS, 32'h0002_0F80, 1'b1, 32'h0002_0FC0, 4'd6}, // R6 last block of page
    '{OP_PULL, 32'h0,         1'b0, 32'h0,         4'd6}, // R6 top edge
    '{OP_MISS, 32'h0003_0080, 1'b0, 32'h0,         4'd2}, // R2
    '{OP_MISS, 32'h0003_0040, 1'b1, 32'h0003_0000, 4'd6}, // R6 first block of page
    '{OP_PULL, 32'h0,         1'b0, 32'h0,         4'd6}, // R6 bottom edge
    '{OP_MISS, 32'h0004_0000, 1'b0, 32'h0,         4'd2}, // R2
    '{OP_MISS, 32'h0004_0100, 1'b0, 32'h0,         4'd2}, // R2 exactly 256 apart
    '{OP_MISS, 32'h0004_0140, 1'b1, 32'h0004_0180, 4'd2}, // R2 64 apart arms
    '{OP_PULL, 32'h0,         1'b1, 32'h0004_01C0, 4'd3}, // R3
    '{OP_PULL, 32'h0,         1'b0, 32'h0,         4'd5}, // R5
    '{OP_MISS, 32'h0005_0000, 1'b0, 32'h0,         4'd2}, // R2
    '{OP_MISS, 32'h0005_0020, 1'b0, 32'h0,         4'd2}, // R2 same block
    '{OP_IDLE, 32'h0,         1'b0, 32'h0,         4'd1}  // R1 quiet
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missValid = 1'b0, hitValid = 1'b0, pfReady = 1'b0;
  logic [31:0] missAddr = '0, hitAddr = '0;
  logic pfValid;
  logic [31:0] pfAddr;
  int total = 0;
  int bad = 0;

  stream_prefetcher dut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .hitValid(hitValid), .hitAddr(hitAddr), .pfReady(pfReady),
    .pfValid(pfValid), .pfAddr(pfAddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkOut(input string req, input logic expV, input logic [31:0] expA);
    total++;
    if (pfValid !== expV || (expV && pfAddr !== expA)) begin
      bad++;
      $display("FAIL %s: got valid=%0b addr=%h, expected valid=%0b addr=%h",
               req, pfValid, pfAddr, expV, expA);
    end
  endtask

  task automatic doStep(input logic [1:0] op, input logic [31:0] a);
    @(negedge clk);
    missValid = (op == OP_MISS);
    hitValid  = (op == OP_HIT);
    pfReady   = (op == OP_PULL);
    missAddr  = a;
    hitAddr   = a;
    @(negedge clk);
    missValid = 1'b0;
    hitValid  = 1'b0;
    pfReady   = 1'b0;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rrExp [6];
    rrExp = '{32'h1080, 32'h2080, 32'h3080, 32'h10C0, 32'h20C0, 32'h30C0};

    repeat (2) @(negedge clk);
    checkOut("R1 in reset", 1'b0, 32'h0);
    applyReset();
    checkOut("R1 after reset", 1'b0, 32'h0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      doStep(TBL[v].op, TBL[v].addr);
      tag = $sformatf("R%0d vec%0d", TBL[v].req, v);
      checkOut(tag, TBL[v].expV, TBL[v].expA);
    end

    // R8 round-robin between three streams
    applyReset();
    doStep(OP_MISS, 32'h1000); doStep(OP_MISS, 32'h1040);
    doStep(OP_MISS, 32'h2000); doStep(OP_MISS, 32'h2040);
    doStep(OP_MISS, 32'h3000); doStep(OP_MISS, 32'h3040);
    for (int k = 0; k < 6; k++) begin
      checkOut($sformatf("R8 grant %0d", k), 1'b1, rrExp[k]);
      doStep(OP_PULL, 32'h0);
    end
    checkOut("R8 drained", 1'b0, 32'h0);

    // R7 eviction of least recently touched page
    applyReset();
    for (int p = 1; p <= 8; p++) doStep(OP_MISS, 32'(p) << 12);
    doStep(OP_MISS, 32'h1000);            // touch page 1 only
    doStep(OP_MISS, 32'h9000);            // evicts page 2
    doStep(OP_MISS, 32'h2040);            // page 2 forgotten: no trigger
    checkOut("R7 evicted page", 1'b0, 32'h0);
    doStep(OP_MISS, 32'h1040);            // page 1 kept
    checkOut("R7 kept page", 1'b1, 32'h1080);

    // R9 offer held while not accepted
    applyReset();
    doStep(OP_MISS, 32'h5000);
    doStep(OP_MISS, 32'h5040);
    checkOut("R9 offer", 1'b1, 32'h5080);
    repeat (4) doStep(OP_IDLE, 32'h0);
    checkOut("R9 held", 1'b1, 32'h5080);
    doStep(OP_PULL, 32'h0);
    checkOut("R9 advanced once", 1'b1, 32'h50C0);

    // R1 reset clears trackers mid-run
    applyReset();
    checkOut("R1 mid-run reset", 1'b0, 32'h0);
    doStep(OP_MISS, 32'h5080);
    checkOut("R1 trackers cleared", 1'b0, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule